// File: doc/BRIEF.md
# Time-of-Day Alarm and Interrupt Controller

This block sits beside a time-of-day counter and turns the counter's state into interrupt requests. It keeps eight alarm bytes, one per counter field, and flags an alarm when every live field that takes part in the comparison equals its alarm byte. Each alarm byte carries its own exclude bit. The hour byte places that bit one position lower than the other fields, because its top bit belongs to the 12-hour afternoon flag.

The block also decodes periodic events from the counter's advance strobe. It recognises a new hundredth, a new tenth, a new second, minute, hour and day. A single interrupt byte does two jobs. A write sets the per-source enable mask. A read returns the pending sources together with a summary flag, and the read clears them. The interrupt pin is a level that follows the pending state, gated by a global enable that comes from outside.

The counters, the advance strobe, the 12/24-hour format and the global enable are all inputs. The block owns only the alarm bytes, the mask and the pending state.

Top module: `tod_alarm_irq`

## Requirements
- R1: The alarm byte of counter field k sits at address 8+k. The field order is 0 hundredths, 1 hour, 2 minute, 3 second, 4 month, 5 day, 6 year, 7 weekday, and counter field k arrives on cnt_i[8k+7:8k]. A written alarm byte reads back unchanged. Addresses 0 to 7 and 17 and above read 0.
- R2: A field is left out of the alarm comparison when bit 7 of its alarm byte is set, except the hour field, which uses bit 6 for this. The exclude bit is also left out of that field's own comparison, so for the hour field bit 7 is compared. The match condition holds when every field that is not left out equals its alarm byte.
- R3: Pending bit 0 (alarm) is set once, on the first cycle the match condition becomes true, and only if mask bit 0 is set. A match that simply continues does not set it again. Setting the mask while a match already holds does not set it either.
- R4: On a cycle with tick_i high, the counter values present in that cycle are the newly advanced ones. The following pending bits are set when their mask bit is set: bit 1 on every tick; bit 2 when hundredths mod 10 is 0; bit 3 when hundredths is 0; bit 4 when, in addition, seconds is 0; bit 5 when, in addition, minutes is 0; bit 6 when, in addition, the hour is midnight. No periodic bit is set without tick_i.
- R5: Midnight is hour byte 0 when fmt24_i is 1. When fmt24_i is 0 it is hour byte 12 (decimal) with bit 7, the afternoon flag, clear.
- R6: Reading address 16 (rd_en_i high) returns the pending byte, and the pending bits clear at that clock edge. Writing address 16 loads mask bits 6:0 from wdata_i and leaves the pending bits unchanged.
- R7: Bit 7 of the byte read at address 16 is the OR of pending bits 6:0.
- R8: An event in the same cycle as a read of address 16 is not lost. It is pending after the read.
- R9: irq_o is high exactly when gie_i is high and at least one pending bit is set.
- R10: After reset the mask, the pending bits, all alarm bytes and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr_i | input | 5 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; clears pending state when addr_i is 16 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| cnt_i | input | 64 | Live counter fields, field k in bits 8k+7:8k |
| tick_i | input | 1 | Counter advanced by one hundredth this cycle |
| fmt24_i | input | 1 | 1 = 24-hour hour coding, 0 = 12-hour coding |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request level |

## Verification
The bench uses the default build: eight 8-bit fields, a 5-bit address, alarm bytes at 8 and the interrupt byte at 16. With this build the whole hundredths range can be swept under several second, minute and hour settings in both hour formats. Every field can also be isolated in turn as the only one taking part in the alarm comparison, so both exclude-bit positions are tested, and each mask bit is gated on its own.

// File: rtl/tod_irq_pkg.sv
package tod_irq_pkg;
  localparam int unsigned FIELD_W  = 8;
  localparam int unsigned N_FIELDS = 8;
  localparam int unsigned N_SRC    = FIELD_W - 1;

  // counter field positions (the alarm bytes follow this order)
  localparam int unsigned F_HSEC = 0;
  localparam int unsigned F_HOUR = 1;
  localparam int unsigned F_MIN  = 2;
  localparam int unsigned F_SEC  = 3;

  // exclude-bit positions inside alarm bytes
  localparam int unsigned IGN_BIT      = 7;
  localparam int unsigned HOUR_IGN_BIT = 6;

  typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_irq_pkg::*;
#(
  parameter int unsigned NF       = N_FIELDS,
  parameter int unsigned W        = FIELD_W,
  parameter int unsigned HOUR_IDX = F_HOUR,
  parameter int unsigned IGN      = IGN_BIT,
  parameter int unsigned HOUR_IGN = HOUR_IGN_BIT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NF-1:0]   wr_sel,
  input  logic [W-1:0]    wdata,
  input  logic [NF*W-1:0] cnt,
  output logic [NF*W-1:0] alarm,
  output logic            match_prev,
  output logic            match_rise
);
  logic [NF-1:0] fld_ok;
  logic          match_now;
  logic          match_d;

  for (genvar k = 0; k < NF; k++) begin : g_fld
    localparam int unsigned IB = (k == HOUR_IDX) ? HOUR_IGN : IGN;
    localparam logic [W-1:0] CMP_MASK = ~(W'(1) << IB);
    logic [W-1:0] al_q;
    logic [W-1:0] al_d;

    always_comb begin
      al_d = al_q;
      if (wr_sel[k]) al_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) al_q <= '0;
      else        al_q <= al_d;
    end

    assign fld_ok[k] = al_q[IB] |
                       (((al_q ^ cnt[k*W +: W]) & CMP_MASK) == '0);
    assign alarm[k*W +: W] = al_q;
  end

  assign match_now = &fld_ok;

  always_comb match_d = match_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_prev <= 1'b0;
    else        match_prev <= match_d;
  end

  assign match_rise = match_now & ~match_prev;
endmodule

// File: rtl/tod_period_detect.sv
module tod_period_detect #(
  parameter int unsigned W         = 8,
  parameter int unsigned TENTH_DIV = 10,
  parameter int unsigned NOON_CODE = 12
) (
  input  logic         tick,
  input  logic         fmt24,
  input  logic [W-1:0] hsec,
  input  logic [W-1:0] sec,
  input  logic [W-1:0] mins,
  input  logic [W-1:0] hour,
  output logic [5:0]   ev
);
  localparam logic [W-1:0] TD   = W'(TENTH_DIV);
  localparam logic [W-1:0] NOON = W'(NOON_CODE);

  logic midnight;
  logic sec_wrap;
  logic min_wrap;
  logic hour_wrap;

  always_comb begin
    midnight  = fmt24 ? (hour == '0) : (hour == NOON);
    sec_wrap  = tick && (hsec == '0);
    min_wrap  = sec_wrap && (sec == '0);
    hour_wrap = min_wrap && (mins == '0);
    ev[0] = tick;
    ev[1] = tick && ((hsec % TD) == '0);
    ev[2] = sec_wrap;
    ev[3] = min_wrap;
    ev[4] = hour_wrap;
    ev[5] = hour_wrap && midnight;
  end
endmodule

// File: rtl/tod_irq_status.sv
module tod_irq_status
  import tod_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t ev,
  input  logic     mask_wr,
  input  src_vec_t mask_in,
  input  logic     rd_clr,
  output src_vec_t mask_q,
  output src_vec_t pend_q
);
  src_vec_t mask_d;
  src_vec_t pend_d;

  always_comb begin
    mask_d = mask_q;
    if (mask_wr) mask_d = mask_in;
    pend_d = (rd_clr ? '0 : pend_q) | (ev & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/tod_alarm_irq.sv
module tod_alarm_irq
  import tod_irq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned ALARM_BASE = 8,
  parameter int unsigned IRQ_ADDR   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        wr_en_i,
  input  logic                        rd_en_i,
  input  logic [FIELD_W-1:0]          wdata_i,
  output logic [FIELD_W-1:0]          rdata_o,
  input  logic [N_FIELDS*FIELD_W-1:0] cnt_i,
  input  logic                        tick_i,
  input  logic                        fmt24_i,
  input  logic                        gie_i,
  output logic                        irq_o
);
  localparam int unsigned NF = N_FIELDS;
  localparam int unsigned W  = FIELD_W;
  localparam logic [ADDR_W-1:0] IRQ_A = ADDR_W'(IRQ_ADDR);

  logic [NF-1:0]   wr_sel;
  logic [NF*W-1:0] alarm_flat;
  logic            match_prev;
  logic            match_rise;
  logic [5:0]      per_ev;
  src_vec_t        ev_all;
  src_vec_t        mask_q;
  src_vec_t        pend_q;
  logic            irq_hit;

  assign irq_hit = (addr_i == IRQ_A);

  for (genvar k = 0; k < NF; k++) begin : g_sel
    assign wr_sel[k] = wr_en_i && (addr_i == ADDR_W'(ALARM_BASE + k));
  end

  tod_alarm_match #(
    .NF(NF), .W(W), .HOUR_IDX(F_HOUR), .IGN(IGN_BIT), .HOUR_IGN(HOUR_IGN_BIT)
  ) u_match (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(wdata_i), .cnt(cnt_i),
    .alarm(alarm_flat), .match_prev(match_prev), .match_rise(match_rise)
  );

  tod_period_detect #(.W(W)) u_period (
    .tick(tick_i), .fmt24(fmt24_i),
    .hsec(cnt_i[F_HSEC*W +: W]), .sec(cnt_i[F_SEC*W +: W]),
    .mins(cnt_i[F_MIN*W +: W]), .hour(cnt_i[F_HOUR*W +: W]),
    .ev(per_ev)
  );

  assign ev_all = {per_ev, match_rise};

  tod_irq_status u_status (
    .clk(clk), .rst_n(rst_n), .ev(ev_all),
    .mask_wr(wr_en_i && irq_hit), .mask_in(wdata_i[N_SRC-1:0]),
    .rd_clr(rd_en_i && irq_hit), .mask_q(mask_q), .pend_q(pend_q)
  );

  always_comb begin
    rdata_o = '0;
    if (irq_hit) rdata_o = {|pend_q, pend_q};
    for (int k = 0; k < NF; k++) begin
      if (addr_i == ADDR_W'(ALARM_BASE + k)) rdata_o = alarm_flat[k*W +: W];
    end
  end

  assign irq_o = gie_i & (|pend_q);
endmodule

// File: rtl/tod_alarm_irq_chk.sv
module tod_alarm_irq_chk
  import tod_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned IRQ_ADDR = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               rd_en_i,
  input logic               tick_i,
  input logic               gie_i,
  input logic               irq_o,
  input logic [FIELD_W-1:0] rdata_o,
  input src_vec_t           pend_q,
  input logic               match_prev
);
  logic rd_hit;
  assign rd_hit = rd_en_i && (addr_i == ADDR_W'(IRQ_ADDR));

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> gie_i);

  p_irq_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_q != '0));

  p_flag_is_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_W'(IRQ_ADDR)) |-> (rdata_o[FIELD_W-1] == (rdata_o[FIELD_W-2:0] != '0)));

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !tick_i) |=> (pend_q[N_SRC-1:1] == '0));

  p_no_tick_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !rd_hit) |=> (pend_q[N_SRC-1:1] == $past(pend_q[N_SRC-1:1])));

  p_alarm_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_prev && !rd_hit) |=> (pend_q[0] == $past(pend_q[0])));
endmodule

bind tod_alarm_irq tod_alarm_irq_chk #(.ADDR_W(ADDR_W), .IRQ_ADDR(IRQ_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_en_i(rd_en_i), .tick_i(tick_i),
  .gie_i(gie_i), .irq_o(irq_o), .rdata_o(rdata_o), .pend_q(pend_q),
  .match_prev(match_prev)
);

// File: tb/tod_alarm_irq_test.sv
module tod_alarm_irq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  addr;
  logic        wr_en, rd_en, tick, fmt24, gie;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [63:0] cnt;
  logic        irq;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  tod_alarm_irq uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .cnt_i(cnt), .tick_i(tick),
    .fmt24_i(fmt24), .gie_i(gie), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 check(tag, rdata, exp);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd_drop();
    @(negedge clk); addr = 5'd16; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_fld(input int k, input logic [7:0] v);
    @(negedge clk); cnt[k*8 +: 8] = v;
  endtask

  task automatic tick_at(input logic [7:0] h, input logic [7:0] hr,
                         input logic [7:0] m, input logic [7:0] s);
    @(negedge clk);
    cnt[7:0] = h; cnt[15:8] = hr; cnt[23:16] = m; cnt[31:24] = s;
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  function automatic logic [7:0] exp_per(input int h, input int s, input int m,
                                         input int hr, input bit f24);
    logic [6:0] e = '0;
    bit mid = f24 ? (hr == 0) : (hr == 12);
    e[1] = 1'b1;
    e[2] = (h % 10) == 0;
    e[3] = (h == 0);
    e[4] = e[3] && (s == 0);
    e[5] = e[4] && (m == 0);
    e[6] = e[5] && mid;
    return {|e, e};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int sv [7], mv [7], hv [7];
    bit fv [7];
    rst_n = 1'b0; addr = '0; wr_en = 0; rd_en = 0; tick = 0; fmt24 = 1;
    gie = 1; wdata = '0; cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    #1 check("R10 irq after reset", {7'd0, irq}, 8'h00);
    rd_chk(5'd16, 8'h00, "R10 pending after reset");
    rd_chk(5'd8,  8'h00, "R10 alarm byte after reset");
    rd_chk(5'd15, 8'h00, "R10 alarm weekday after reset");

    // R1: alarm byte map and readback
    for (int k = 0; k < 8; k++) wr(5'(8 + k), 8'(8'h10 + k));
    for (int k = 0; k < 8; k++) rd_chk(5'(8 + k), 8'(8'h10 + k), "R1 alarm readback");
    rd_chk(5'd3,  8'h00, "R1 counter address reads 0");
    rd_chk(5'd20, 8'h00, "R1 unused address reads 0");

    // R4 R5 R7: hundredths sweep under several settings, mask all periodic
    wr(5'd16, 8'h7E);
    rd_drop();
    sv = '{0, 0, 0, 1, 0, 0, 0};
    mv = '{0, 0, 0, 0, 3, 0, 0};
    hv = '{0, 12, 5, 0, 0, 140, 0};
    fv = '{1, 0, 1, 1, 1, 0, 0};
    for (int c = 0; c < 7; c++) begin
      fmt24 = fv[c];
      for (int h = 0; h < 100; h++) begin
        tick_at(8'(h), 8'(hv[c]), 8'(mv[c]), 8'(sv[c]));
        rd_chk(5'd16, exp_per(h, sv[c], mv[c], hv[c], fv[c]), "R4 R5 R7 periodic sweep");
      end
    end
    fmt24 = 1'b1;

    // R4: each mask bit gates its own source
    for (int i = 1; i < 7; i++) begin
      wr(5'd16, 8'(1 << i));
      tick_at(8'd0, 8'd0, 8'd0, 8'd0);
      rd_chk(5'd16, 8'(8'h80 | (1 << i)), "R4 single mask bit");
    end
    wr(5'd16, 8'h00);
    tick_at(8'd0, 8'd0, 8'd0, 8'd0);
    rd_chk(5'd16, 8'h00, "R4 all masked");

    // R8: event in the read cycle survives
    wr(5'd16, 8'h02);
    @(negedge clk); cnt[7:0] = 8'd7; tick = 1'b1; addr = 5'd16; rd_en = 1'b1;
    #1 check("R8 read during event sees old", rdata, 8'h00);
    @(negedge clk); tick = 1'b0; rd_en = 1'b0;
    rd_chk(5'd16, 8'h82, "R8 event kept after read");

    // R6 R9: mask write keeps pending; irq gating
    tick_at(8'd8, 8'd0, 8'd0, 8'd0);
    wr(5'd16, 8'h7F);
    @(negedge clk); gie = 1'b0;
    #1 check("R9 irq low without enable", {7'd0, irq}, 8'h00);
    @(negedge clk); gie = 1'b1;
    #1 check("R9 irq high with pending", {7'd0, irq}, 8'h01);
    rd_chk(5'd16, 8'h82, "R6 mask write left pending");
    #1 check("R9 irq low after clear", {7'd0, irq}, 8'h00);
    rd_chk(5'd16, 8'h00, "R6 cleared by read");

    // R2 R3: each field alone in the compare
    wr(5'd16, 8'h01);
    @(negedge clk); cnt = {8{8'h14}};
    for (int k = 0; k < 8; k++) begin
      wr(5'(8 + k), 8'h15);
      for (int j = 0; j < 8; j++)
        if (j != k) wr(5'(8 + j), (j == 1) ? 8'h40 : 8'h80);
      @(negedge clk); cnt = {8{8'h14}};
      rd_drop();
      rd_chk(5'd16, 8'h00, "R2 field mismatch no alarm");
      set_fld(k, 8'h15);
      rd_chk(5'd16, 8'h81, "R2 R3 field match raises alarm");
      rd_chk(5'd16, 8'h00, "R3 held match fires once");
    end

    // R2: hour compares bit 7; other fields compare bit 6
    wr(5'd9, 8'h95);
    for (int j = 0; j < 8; j++) if (j != 1) wr(5'(8 + j), 8'h80);
    @(negedge clk); cnt = {8{8'h14}}; cnt[15:8] = 8'h15;
    rd_drop();
    rd_chk(5'd16, 8'h00, "R2 hour bit7 compared");
    set_fld(1, 8'h95);
    rd_chk(5'd16, 8'h81, "R2 hour full match");
    wr(5'd10, 8'h55);
    wr(5'd9, 8'h40);
    @(negedge clk); cnt[23:16] = 8'h15;
    rd_drop();
    rd_chk(5'd16, 8'h00, "R2 minute bit6 compared");
    set_fld(2, 8'h55);
    rd_chk(5'd16, 8'h81, "R2 minute match");

    // R3: alarm masked, then mask set during held match
    set_fld(2, 8'h15);
    wr(5'd16, 8'h00);
    set_fld(2, 8'h55);
    rd_chk(5'd16, 8'h00, "R3 masked alarm not pending");
    wr(5'd16, 8'h01);
    rd_chk(5'd16, 8'h00, "R3 mask set during match no fire");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule